// File: doc/BRIEF.md
# Lock-Protected Clock Synthesizer Divider Register

This block holds the divider settings of a programmable clock synthesizer behind a small word-addressed register interface. It has two words. One is a lock word that accepts a 16-bit unlock key. The other is a settings word that carries the feedback divider v, the reference divider r and the output divider s. Software changes the settings in three steps. It writes the key, then writes the settings word, then writes zero to the lock word to close it again. While the block is locked, writes to the settings word are dropped. Reads are allowed at all times.

A build parameter selects one of five field layouts: a generic full layout and four reduced layouts (core clock, memory clock, system clock, PCI clock). Each layout has its own write mask, and some layouts hardwire some divider values. The block decodes the stored word into the v, r and s outputs that the synthesizer uses. Bits that are outside the mask, or hardwired off, never reach those outputs.

The bus has no stall. A request is taken in the cycle in which `bus_valid` is high. The read data comes back one cycle later with `rd_valid`.

Top module: `osc_ctrl_regs`

## Requirements
- R1: After reset the block is locked and the settings word holds the parameter RESET_VAL. The outputs v, r and s show the decode of RESET_VAL.
- R2: A write of exactly 32'h0000_A05F to the lock word (index LOCK_IDX, default 0) unlocks the block. Any other value, including one that has the key in bits [15:0] and other bits set higher up, leaves the block locked.
- R3: A write to the settings word (index VCO_IDX, default 1) while the block is locked is ignored. The stored word and the v, r and s outputs keep their values.
- R4: A write of any value other than the key to the lock word locks the block. Zero is one such value.
- R5: An accepted write replaces only the bits inside the layout mask and keeps every other bit. The masks are: generic 32'h0007_FFFF, core 32'h0000_07FF, memory 32'h007F_F000, system 32'h0000_00FF, PCI 32'h0000_0100.
- R6: In the generic layout the outputs are taken from the word as follows: v = bits [8:0], r = bits [15:9], s = bits [17:16], with s zero-extended to 3 bits.
- R7: In the core layout the outputs are: v = bits [7:0] with v bit 8 fixed at 0, s = bits [10:8], and r fixed at 22.
- R8: In the memory layout the outputs are: v = bits [19:12] with v bit 8 fixed at 0, s = bits [22:20], and r fixed at 22.
- R9: In the system layout v = bits [7:0], r is fixed at 46 and s is fixed at 3.
- R10: In the PCI layout, word bit 8 set gives v=17, r=22, s=1. Bit 8 clear gives v=14, r=14, s=1.
- R11: A read of the lock word returns the lock status in bit 16 (1 = locked) and zero in all other bits. A read of any index other than the two words returns zero.
- R12: `rd_valid` is high, and `rd_data` holds the read value, in the cycle after a request with `bus_valid` and `bus_read` high and `bus_write` low. `rd_valid` is low in every other cycle. Reads are served whether the block is locked or not.
- R13: v, r and s change only on the clock edge that takes an accepted settings write, and never in other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | Write strobe (takes priority over read) |
| bus_read | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word index |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the read request |
| rd_data | output | 32 | Read data |
| div_v | output | 9 | Decoded feedback divider |
| div_r | output | 7 | Decoded reference divider |
| div_s | output | 3 | Decoded output divider |

## Verification
The bench builds five copies of the block on one shared bus, one copy per LAYOUT value. All five use RESET_VAL 32'hA500_0000. Because the upper byte of that value lies outside every mask, any write that leaks past a mask shows up in a read. Writing all ones and then a mixed pattern exercises every mask and every decode rule, including the hardwired constants and both PCI selections. Each lock step is driven on all five copies at the same time, and so is the key near-miss with high bits set.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int DATA_W   = 32;
  localparam int V_W      = 9;
  localparam int R_W      = 7;
  localparam int S_W      = 3;
  localparam int LOCK_BIT = 16;

  typedef enum logic [2:0] {
    LAY_GENERIC = 3'd0,
    LAY_CORE    = 3'd1,
    LAY_MEM     = 3'd2,
    LAY_SYS     = 3'd3,
    LAY_PCI     = 3'd4
  } osc_layout_e;

  localparam logic [R_W-1:0] FIXED_R_CM  = 7'd22;
  localparam logic [R_W-1:0] FIXED_R_SYS = 7'd46;
  localparam logic [S_W-1:0] FIXED_S_SYS = 3'd3;
  localparam logic [V_W-1:0] PCI_V_HI    = 9'd17;
  localparam logic [R_W-1:0] PCI_R_HI    = 7'd22;
  localparam logic [V_W-1:0] PCI_V_LO    = 9'd14;
  localparam logic [R_W-1:0] PCI_R_LO    = 7'd14;
  localparam logic [S_W-1:0] PCI_S       = 3'd1;

  function automatic logic [DATA_W-1:0] layout_mask(osc_layout_e lay);
    case (lay)
      LAY_CORE: layout_mask = 32'h0000_07FF;
      LAY_MEM:  layout_mask = 32'h007F_F000;
      LAY_SYS:  layout_mask = 32'h0000_00FF;
      LAY_PCI:  layout_mask = 32'h0000_0100;
      default:  layout_mask = 32'h0007_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/osc_bus_decode.sv
module osc_bus_decode #(
  parameter int ADDR_W   = 4,
  parameter int LOCK_IDX = 0,
  parameter int VCO_IDX  = 1
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_read,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              lock_wr,
  output logic              vco_wr,
  output logic              rd_req,
  output logic              rd_lock,
  output logic              rd_vco
);
  localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_IDX);
  localparam logic [ADDR_W-1:0] VCO_A  = ADDR_W'(VCO_IDX);

  logic wr_hit;
  logic hit_lock;
  logic hit_vco;

  always_comb begin
    wr_hit   = bus_valid && bus_write;
    rd_req   = bus_valid && bus_read && !bus_write;
    hit_lock = (bus_addr == LOCK_A);
    hit_vco  = (bus_addr == VCO_A);
    lock_wr  = wr_hit && hit_lock;
    vco_wr   = wr_hit && hit_vco;
    rd_lock  = rd_req && hit_lock;
    rd_vco   = rd_req && hit_vco;
  end
endmodule

// File: rtl/osc_lock_ctrl.sv
module osc_lock_ctrl #(
  parameter int                      DATA_W = 32,
  parameter logic [DATA_W-1:0]       KEY    = 32'h0000_A05F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              locked
);
  logic key_match;

  always_comb key_match = (wdata == KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1;
    end else if (lock_wr) begin
      locked <= !key_match;
    end
  end
endmodule

// File: rtl/osc_vco_store.sv
module osc_vco_store #(
  parameter int                DATA_W    = 32,
  parameter logic [DATA_W-1:0] MASK      = 32'h0007_FFFF,
  parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              locked,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word_q,
  output logic              accepted
);
  logic [DATA_W-1:0] merged;

  always_comb begin
    accepted = wr_req && !locked;
    merged   = (word_q & ~MASK) | (wdata & MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= RESET_VAL;
    end else if (accepted) begin
      word_q <= merged;
    end
  end
endmodule

// File: rtl/osc_field_decode.sv
module osc_field_decode
  import osc_pkg::*;
#(
  parameter osc_layout_e LAYOUT = LAY_GENERIC
) (
  input  logic [DATA_W-1:0] word,
  output logic [V_W-1:0]    v,
  output logic [R_W-1:0]    r,
  output logic [S_W-1:0]    s
);
  logic unused_fold;
  assign unused_fold = ^word;

  if (LAYOUT == LAY_CORE) begin : g_core
    always_comb begin
      v = {1'b0, word[7:0]};
      r = FIXED_R_CM;
      s = word[10:8];
    end
  end else if (LAYOUT == LAY_MEM) begin : g_mem
    always_comb begin
      v = {1'b0, word[19:12]};
      r = FIXED_R_CM;
      s = word[22:20];
    end
  end else if (LAYOUT == LAY_SYS) begin : g_sys
    always_comb begin
      v = {1'b0, word[7:0]};
      r = FIXED_R_SYS;
      s = FIXED_S_SYS;
    end
  end else if (LAYOUT == LAY_PCI) begin : g_pci
    always_comb begin
      v = word[8] ? PCI_V_HI : PCI_V_LO;
      r = word[8] ? PCI_R_HI : PCI_R_LO;
      s = PCI_S;
    end
  end else begin : g_generic
    always_comb begin
      v = word[8:0];
      r = word[15:9];
      s = {1'b0, word[17:16]};
    end
  end
endmodule

// File: rtl/osc_ctrl_regs.sv
module osc_ctrl_regs
  import osc_pkg::*;
#(
  parameter osc_layout_e       LAYOUT    = LAY_GENERIC,
  parameter int                ADDR_W    = 4,
  parameter int                LOCK_IDX  = 0,
  parameter int                VCO_IDX   = 1,
  parameter logic [DATA_W-1:0] KEY       = 32'h0000_A05F,
  parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_read,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [V_W-1:0]    div_v,
  output logic [R_W-1:0]    div_r,
  output logic [S_W-1:0]    div_s
);
  localparam logic [DATA_W-1:0] WR_MASK = layout_mask(LAYOUT);

  logic              lock_wr, vco_wr, rd_req, rd_lock, rd_vco;
  logic              locked_q;
  logic              vco_acc;
  logic [DATA_W-1:0] vco_q;
  logic [DATA_W-1:0] lock_word;
  logic [DATA_W-1:0] rd_next;

  osc_bus_decode #(.ADDR_W(ADDR_W), .LOCK_IDX(LOCK_IDX), .VCO_IDX(VCO_IDX)) dec_i (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_read(bus_read),
    .bus_addr(bus_addr), .lock_wr(lock_wr), .vco_wr(vco_wr),
    .rd_req(rd_req), .rd_lock(rd_lock), .rd_vco(rd_vco)
  );

  osc_lock_ctrl #(.DATA_W(DATA_W), .KEY(KEY)) lock_i (
    .clk(clk), .rst_n(rst_n), .lock_wr(lock_wr),
    .wdata(bus_wdata), .locked(locked_q)
  );

  osc_vco_store #(.DATA_W(DATA_W), .MASK(WR_MASK), .RESET_VAL(RESET_VAL)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_req(vco_wr), .locked(locked_q),
    .wdata(bus_wdata), .word_q(vco_q), .accepted(vco_acc)
  );

  osc_field_decode #(.LAYOUT(LAYOUT)) fld_i (
    .word(vco_q), .v(div_v), .r(div_r), .s(div_s)
  );

  always_comb begin
    lock_word           = '0;
    lock_word[LOCK_BIT] = locked_q;
    if (rd_lock)     rd_next = lock_word;
    else if (rd_vco) rd_next = vco_q;
    else             rd_next = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= rd_next;
    end
  end

  logic unused_acc;
  assign unused_acc = vco_acc;
endmodule

// File: rtl/osc_ctrl_chk.sv
module osc_ctrl_chk
  import osc_pkg::*;
#(
  parameter osc_layout_e       LAYOUT   = LAY_GENERIC,
  parameter int                ADDR_W   = 4,
  parameter int                LOCK_IDX = 0,
  parameter int                VCO_IDX  = 1,
  parameter logic [DATA_W-1:0] KEY      = 32'h0000_A05F
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic              bus_read,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rd_valid,
  input logic              locked_q,
  input logic [DATA_W-1:0] vco_q,
  input logic [V_W-1:0]    div_v,
  input logic [R_W-1:0]    div_r,
  input logic [S_W-1:0]    div_s
);
  localparam logic [DATA_W-1:0] M = layout_mask(LAYOUT);

  logic lock_w, vco_w, rd_w;
  always_comb begin
    lock_w = bus_valid && bus_write && (bus_addr == ADDR_W'(LOCK_IDX));
    vco_w  = bus_valid && bus_write && (bus_addr == ADDR_W'(VCO_IDX));
    rd_w   = bus_valid && bus_read && !bus_write;
  end

  a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_w && bus_wdata == KEY) |=> !locked_q);

  a_r4_other_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_w && bus_wdata != KEY) |=> locked_q);

  a_r3_locked_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (vco_w && locked_q) |=> $stable(vco_q));

  a_r5_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((vco_q & ~M) == ($past(vco_q) & ~M)));

  a_r12_rd_timing: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rd_valid == $past(rd_w)));

  a_r13_outs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(vco_w && !locked_q) |=> $stable({div_v, div_r, div_s}));
endmodule

bind osc_ctrl_regs osc_ctrl_chk #(
  .LAYOUT(LAYOUT), .ADDR_W(ADDR_W), .LOCK_IDX(LOCK_IDX),
  .VCO_IDX(VCO_IDX), .KEY(KEY)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_read(bus_read), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .rd_valid(rd_valid), .locked_q(locked_q), .vco_q(vco_q),
  .div_v(div_v), .div_r(div_r), .div_s(div_s)
);

// File: tb/osc_ctrl_regs_tb_top.sv
module osc_ctrl_regs_tb_top;
  import osc_pkg::*;

  localparam logic [31:0] RV  = 32'hA500_0000;
  localparam logic [31:0] KEYV = 32'h0000_A05F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0, bus_read = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rv [5];
  logic [31:0] rd [5];
  logic [8:0]  dv [5];
  logic [6:0]  dr [5];
  logic [2:0]  ds [5];
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  osc_ctrl_regs #(.LAYOUT(LAY_GENERIC), .RESET_VAL(RV)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_read(bus_read), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rv[0]), .rd_data(rd[0]), .div_v(dv[0]), .div_r(dr[0]), .div_s(ds[0]));
  osc_ctrl_regs #(.LAYOUT(LAY_CORE), .RESET_VAL(RV)) dut_core (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_read(bus_read), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rv[1]), .rd_data(rd[1]), .div_v(dv[1]), .div_r(dr[1]), .div_s(ds[1]));
  osc_ctrl_regs #(.LAYOUT(LAY_MEM), .RESET_VAL(RV)) dut_mem (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_read(bus_read), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rv[2]), .rd_data(rd[2]), .div_v(dv[2]), .div_r(dr[2]), .div_s(ds[2]));
  osc_ctrl_regs #(.LAYOUT(LAY_SYS), .RESET_VAL(RV)) dut_sys (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_read(bus_read), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rv[3]), .rd_data(rd[3]), .div_v(dv[3]), .div_r(dr[3]), .div_s(ds[3]));
  osc_ctrl_regs #(.LAYOUT(LAY_PCI), .RESET_VAL(RV)) dut_pci (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_read(bus_read), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rv[4]), .rd_data(rd[4]), .div_v(dv[4]), .div_r(dr[4]), .div_s(ds[4]));

  task automatic chk(string req, int idx, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s dut%0d actual=0x%08h expected=0x%08h", req, idx, act, exp);
    end
  endtask

  task automatic chk_outs(string req, int idx, logic [8:0] v, logic [6:0] r, logic [2:0] s);
    chk(req, idx, {13'd0, dv[idx], dr[idx], ds[idx]}, {13'd0, v, r, s});
  endtask

  task automatic do_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic do_read(logic [3:0] a);
    @(negedge clk);
    bus_valid = 1'b1; bus_read = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0; bus_read = 1'b0;
    for (int i = 0; i < 5; i++) chk("R12 rd_valid", i, {31'd0, rv[i]}, 32'd1);
  endtask

  task automatic expect_lock(string req, logic lk);
    do_read(4'd0);
    for (int i = 0; i < 5; i++) chk(req, i, rd[i], {15'd0, lk, 16'd0});
  endtask

  task automatic expect_words(string req, logic [31:0] e0, logic [31:0] e1,
                              logic [31:0] e2, logic [31:0] e3, logic [31:0] e4);
    logic [31:0] e [5];
    e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3; e[4] = e4;
    do_read(4'd1);
    for (int i = 0; i < 5; i++) chk(req, i, rd[i], e[i]);
  endtask

  task automatic t_reset;
    @(negedge clk);
    for (int i = 0; i < 5; i++) chk("R12 idle rd_valid low", i, {31'd0, rv[i]}, 32'd0);
    chk_outs("R1 reset decode generic", 0, 9'd0, 7'd0, 3'd0);
    chk_outs("R1 reset decode core", 1, 9'd0, 7'd22, 3'd0);
    chk_outs("R1 reset decode mem", 2, 9'd0, 7'd22, 3'd0);
    chk_outs("R1 reset decode sys", 3, 9'd0, 7'd46, 3'd3);
    chk_outs("R1 reset decode pci", 4, 9'd14, 7'd14, 3'd1);
    expect_lock("R1 reset locked", 1'b1);
    expect_words("R1 reset word", RV, RV, RV, RV, RV);
  endtask

  task automatic t_locked_write;
    do_write(4'd1, 32'hFFFF_FFFF);
    expect_words("R3 locked write ignored", RV, RV, RV, RV, RV);
    chk_outs("R3 outputs unchanged", 0, 9'd0, 7'd0, 3'd0);
    chk_outs("R3 outputs unchanged", 4, 9'd14, 7'd14, 3'd1);
  endtask

  task automatic t_near_key;
    do_write(4'd0, 32'h0001_A05F);
    expect_lock("R2 near-miss key stays locked", 1'b1);
    do_write(4'd1, 32'hFFFF_FFFF);
    expect_words("R2 near-miss no write", RV, RV, RV, RV, RV);
  endtask

  task automatic t_unlock_all_ones;
    do_write(4'd0, KEYV);
    expect_lock("R2 key unlocks", 1'b0);
    expect_lock("R11 lock read unlocked", 1'b0);
    do_write(4'd1, 32'hFFFF_FFFF);
    expect_words("R5 mask all ones", 32'hA507_FFFF, 32'hA500_07FF,
                 32'hA57F_F000, 32'hA500_00FF, 32'hA500_0100);
    chk_outs("R6 generic all ones", 0, 9'h1FF, 7'h7F, 3'd3);
    chk_outs("R7 core all ones", 1, 9'h0FF, 7'd22, 3'd7);
    chk_outs("R8 mem all ones", 2, 9'h0FF, 7'd22, 3'd7);
    chk_outs("R9 sys all ones", 3, 9'h0FF, 7'd46, 3'd3);
    chk_outs("R10 pci bit8 set", 4, 9'd17, 7'd22, 3'd1);
  endtask

  task automatic t_pattern;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'd1; bus_wdata = 32'h0001_2A05;
    #1;
    chk_outs("R13 no change before edge", 0, 9'h1FF, 7'h7F, 3'd3);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    chk_outs("R6 generic pattern", 0, 9'h005, 7'h15, 3'd1);
    chk_outs("R7 core pattern", 1, 9'h005, 7'd22, 3'd2);
    chk_outs("R8 mem pattern", 2, 9'h012, 7'd22, 3'd0);
    chk_outs("R9 sys pattern", 3, 9'h005, 7'd46, 3'd3);
    chk_outs("R10 pci bit8 clear", 4, 9'd14, 7'd14, 3'd1);
    expect_words("R5 mask pattern", 32'hA501_2A05, 32'hA500_0205,
                 32'hA501_2000, 32'hA500_0005, 32'hA500_0000);
    chk_outs("R13 held after read", 0, 9'h005, 7'h15, 3'd1);
  endtask

  task automatic t_relock;
    do_write(4'd0, 32'h0000_1234);
    expect_lock("R4 other value locks", 1'b1);
    do_write(4'd0, KEYV);
    do_write(4'd0, 32'h0000_0000);
    expect_lock("R4 zero locks", 1'b1);
    do_write(4'd1, 32'h0000_0000);
    expect_words("R3 write after relock ignored", 32'hA501_2A05, 32'hA500_0205,
                 32'hA501_2000, 32'hA500_0005, 32'hA500_0000);
  endtask

  task automatic t_other_addr;
    do_read(4'd7);
    for (int i = 0; i < 5; i++) chk("R11 unmapped read zero", i, rd[i], 32'd0);
    @(negedge clk);
    for (int i = 0; i < 5; i++) chk("R12 rd_valid drops", i, {31'd0, rv[i]}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_locked_write();
    t_near_key();
    t_unlock_all_ones();
    t_pattern();
    t_relock();
    t_other_addr();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule